// File: doc/BRIEF.md
# DAC Channel Trigger and DMA Request Controller

This block sits in front of one digital-to-analog data channel. Software or a DMA engine loads a 12-bit sample into a holding register. When the selected trigger fires, the block copies that sample into the output register that feeds the converter. A 3-bit source select chooses the trigger. Codes 0 to 6 pick one of seven external trigger lines. Code 7 picks a software strobe.

External lines are asynchronous to the block clock. Each line passes through a two-stage synchronizer and a rising-edge detector, so one pulse counts as one trigger, however long the pulse lasts. The output register is loaded on the third clock edge after the line rises. A software strobe loads the output register on the very next edge. When DMA is enabled, an external trigger raises a request so that the DMA engine can refill the holding register. The request stays high until the engine acknowledges it. The block never queues requests. A trigger that arrives while a request is still pending gets no request of its own. A channel used alone or as half of a pair behaves the same: each channel whose DMA enable is set produces its own request stream.

Top module: `dac_trig_ctrl`

## Requirements
- R1: The source select can be written only while `chan_en` is low. A `sel_wr` strobe while `chan_en` is high leaves the select unchanged.
- R2: With select code 7, a `sw_trig` high at a rising clock edge while enabled loads `dout` from the holding register at that same edge. With any other select code, `sw_trig` has no effect.
- R3: A software trigger never raises `dma_req`.
- R4: With select code k (0 to 6), a rising edge on `ext_trig[k]` that is high before clock edge E1 loads `dout` at edge E3, and not before. Each pulse gives exactly one transfer. Lines that are not selected are ignored.
- R5: An external trigger with `dma_en` high raises `dma_req` at the same edge that loads `dout`. With `dma_en` low, no request is raised.
- R6: `dma_req` stays high until `dma_ack` is sampled high, and it falls at that edge.
- R7: An external trigger that arrives while `dma_req` is high still loads `dout`. It produces no additional request, neither at once nor after the acknowledge.
- R8: While `chan_en` is low, triggers change neither `dout` nor `dma_req`.
- R9: After reset, `dout` is 0, `dma_req` is 0 and the select code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| sel_wr | input | 1 | Write strobe for the trigger source select |
| sel_wdata | input | 3 | New source select (0 to 6 external, 7 software) |
| ext_trig | input | 7 | Asynchronous external trigger lines |
| sw_trig | input | 1 | Software trigger strobe, one clock wide |
| dma_en | input | 1 | DMA request enable |
| dma_ack | input | 1 | DMA acknowledge |
| hold_wr | input | 1 | Holding register write strobe |
| hold_wdata | input | 12 | Holding register write data |
| dout | output | 12 | Output register value |
| dma_req | output | 1 | DMA request |

## Verification
The bench pushes an expected output value into a scoreboard for every transfer and flags any change of `dout` that was not predicted. This catches designs that transfer on an unselected line, on a long pulse more than once, on a software strobe under an external select, or while disabled. It samples `dout` one edge before the expected load, which exposes a synchronizer that is too short or too long. It sends a second trigger while a request is pending and then acknowledges. A design that queued the request would raise it again, and a design that dropped the transfer along with the request would miss the scoreboard value. It also tries to write the select while enabled, so a design with an unfrozen select would transfer on the wrong source.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int unsigned DATA_W      = 12;
  localparam int unsigned SEL_W       = 3;
  localparam int unsigned NUM_EXT     = (1 << SEL_W) - 1;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int unsigned N      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], lines_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign rise_o[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned NUM_EXT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   sel_wdata,
  input  logic [NUM_EXT-1:0] rise_i,
  input  logic               sw_trig,
  output logic               ext_evt_o,
  output logic               sw_evt_o
);
  localparam int unsigned    CODES  = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_SW = SEL_W'(CODES - 1);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CODES-1:0] rise_pad;

  always_comb begin
    sel_d = sel_q;
    if (sel_wr && !chan_en) sel_d = sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  always_comb begin
    rise_pad              = '0;
    rise_pad[NUM_EXT-1:0] = rise_i;
  end

  assign ext_evt_o = chan_en && (sel_q != SEL_SW) && rise_pad[sel_q];
  assign sw_evt_o  = chan_en && (sel_q == SEL_SW) && sw_trig;

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(sel_q)); // R1
endmodule

// File: rtl/dac_dma_req.sv
module dac_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic dma_ack,
  input  logic ext_evt,
  output logic dma_req
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (req_q && dma_ack)                  req_d = 1'b0;
    else if (!req_q && ext_evt && dma_en)  req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign dma_req = req_q;

  AST_REQ_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !ext_evt) |=> !req_q); // R3
  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && ext_evt && dma_en) |=> req_q); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !dma_ack) |=> req_q); // R6
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && dma_ack) |=> !req_q); // R6
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int unsigned P_DATA_W  = DATA_W,
  parameter int unsigned P_SEL_W   = SEL_W,
  parameter int unsigned P_NUM_EXT = NUM_EXT,
  parameter int unsigned P_STAGES  = SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_en,
  input  logic                 sel_wr,
  input  logic [P_SEL_W-1:0]   sel_wdata,
  input  logic [P_NUM_EXT-1:0] ext_trig,
  input  logic                 sw_trig,
  input  logic                 dma_en,
  input  logic                 dma_ack,
  input  logic                 hold_wr,
  input  logic [P_DATA_W-1:0]  hold_wdata,
  output logic [P_DATA_W-1:0]  dout,
  output logic                 dma_req
);
  logic                 rst_meta_q, rst_sync_n;
  logic [P_NUM_EXT-1:0] rise;
  logic                 ext_evt, sw_evt, xfer;
  logic [P_DATA_W-1:0]  hold_q, hold_d, dout_q, dout_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dac_trig_sync #(.N(P_NUM_EXT), .STAGES(P_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lines_i (ext_trig),
    .rise_o  (rise)
  );

  dac_trig_sel #(.SEL_W(P_SEL_W), .NUM_EXT(P_NUM_EXT)) u_sel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .chan_en   (chan_en),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .rise_i    (rise),
    .sw_trig   (sw_trig),
    .ext_evt_o (ext_evt),
    .sw_evt_o  (sw_evt)
  );

  dac_dma_req u_dma (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dma_en  (dma_en),
    .dma_ack (dma_ack),
    .ext_evt (ext_evt),
    .dma_req (dma_req)
  );

  assign xfer = ext_evt | sw_evt;

  always_comb begin
    hold_d = hold_q;
    if (hold_wr) hold_d = hold_wdata;
    dout_d = dout_q;
    if (xfer) dout_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= '0;
      dout_q <= '0;
    end else begin
      hold_q <= hold_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  AST_SW_XFER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_evt |=> (dout_q == $past(hold_q))); // R2
  AST_EXT_XFER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_evt |=> (dout_q == $past(hold_q))); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chan_en |=> $stable(dout_q)); // R8
  AST_NO_DUAL_EVT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ext_evt && sw_evt)); // R2
endmodule

// File: tb/dac_trig_ctrl_tb.sv
module dac_trig_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_en, sel_wr, sw_trig, dma_en, dma_ack, hold_wr;
  logic [2:0]  sel_wdata;
  logic [6:0]  ext_trig;
  logic [11:0] hold_wdata, dout;
  logic        dma_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit mon_on = 0;
  logic [11:0] last_dout;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_trig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .ext_trig(ext_trig), .sw_trig(sw_trig),
    .dma_en(dma_en), .dma_ack(dma_ack), .hold_wr(hold_wr),
    .hold_wdata(hold_wdata), .dout(dout), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: every change of dout must match the next expected item
  always @(negedge clk) begin
    if (mon_on && dout !== last_dout) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected transfer actual=%0h expected=%0h", dout, last_dout);
      end else begin
        chk(tag_q.pop_front(), dout, exp_q.pop_front());
      end
      last_dout = dout;
    end
  end

  task automatic push(input logic [11:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wr_hold(input logic [11:0] v);
    @(negedge clk); hold_wr = 1'b1; hold_wdata = v;
    @(negedge clk); hold_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic [2:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  // two-cycle pulse; returns at the negedge after the third clock edge
  task automatic pulse(input int idx, input logic [11:0] old_v, input bit chk_lat);
    @(negedge clk); ext_trig[idx] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (chk_lat) chk("R4 no load before third edge", dout, old_v);
    ext_trig[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chan_en = 0; sel_wr = 0; sel_wdata = 0; ext_trig = '0;
    sw_trig = 0; dma_en = 0; dma_ack = 0; hold_wr = 0; hold_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 dout after reset", dout, 12'h0);
    chk("R9 dma_req after reset", dma_req, 1'b0);
    last_dout = dout; mon_on = 1;

    chan_en = 1;
    // R9: select resets to code 0, so line 0 triggers
    wr_hold(12'h123); push(12'h123, "R9 select code 0 after reset");
    pulse(0, 12'h0, 1);
    chk("R4 load at third edge", dout, 12'h123);
    chk("R5 no request with dma_en low", dma_req, 1'b0);

    // R4: unselected line ignored
    wr_hold(12'h124);
    pulse(3, 12'h123, 0);
    repeat (3) @(negedge clk);
    chk("R4 unselected line ignored", dout, 12'h123);

    // R4: long pulse gives one transfer
    push(12'h124, "R4 long pulse first transfer");
    @(negedge clk); ext_trig[0] = 1'b1;
    repeat (8) @(negedge clk);
    wr_hold(12'h125);
    ext_trig[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 one transfer per pulse", dout, 12'h124);

    // R5/R6: request raise, hold, clear
    dma_en = 1;
    wr_hold(12'h456); push(12'h456, "R5 transfer with dma");
    pulse(0, 12'h124, 0);
    chk("R5 request raised with transfer", dma_req, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 request held without ack", dma_req, 1'b1);
    ack();
    chk("R6 request cleared by ack", dma_req, 1'b0);

    // R7: trigger during pending request
    wr_hold(12'h111); push(12'h111, "R7 first transfer");
    pulse(0, 12'h456, 0);
    chk("R7 request pending", dma_req, 1'b1);
    wr_hold(12'h222); push(12'h222, "R7 transfer while pending");
    pulse(0, 12'h111, 0);
    chk("R7 dout loaded while pending", dout, 12'h222);
    chk("R7 request still single", dma_req, 1'b1);
    ack();
    chk("R7 request cleared", dma_req, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 no queued request", dma_req, 1'b0);

    // R1/R2/R3: select software while disabled, then try to change while enabled
    chan_en = 0;
    wr_sel(3'd7);
    chan_en = 1;
    wr_sel(3'd2);
    wr_hold(12'h333); push(12'h333, "R2 software transfer");
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
    chk("R2 software load after one edge", dout, 12'h333);
    chk("R3 software trigger no request", dma_req, 1'b0);
    wr_hold(12'h334);
    pulse(2, 12'h333, 0);
    repeat (2) @(negedge clk);
    chk("R1 select write while enabled ignored", dout, 12'h333);
    chk("R3 no request from ignored line", dma_req, 1'b0);

    // R2: software strobe ignored with external select; R1 write accepted
    chan_en = 0;
    wr_sel(3'd5);
    chan_en = 1;
    wr_hold(12'h444);
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 software strobe ignored", dout, 12'h333);
    push(12'h444, "R1 select written while disabled");
    pulse(5, 12'h333, 1);
    chk("R1 line 5 selected", dout, 12'h444);
    chk("R5 request from line 5", dma_req, 1'b1);
    ack();

    // R8: disabled channel ignores triggers
    chan_en = 0;
    wr_hold(12'h555);
    pulse(5, 12'h444, 0);
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 dout unchanged while disabled", dout, 12'h444);
    chk("R8 no request while disabled", dma_req, 1'b0);

    chk("R4 all expected transfers seen", exp_q.size(), 0);
    finish_run();
  end
endmodule